// File: doc/BRIEF.md
# Reconfigurable Inner-Product and Determinant Datapath

This block is a small fixed-point arithmetic unit that sits beside a processor pipeline and runs the macro operations of a rotation-based QR update. A single bank of four signed multipliers feeds a two-level adder tree. A separate configure command re-shapes that hardware into one of five operations: a scalar product, inner products of two, three or four element vectors, or a pair of independent 2x2 determinants that run side by side and keep all four multipliers busy.

The inner-product modes serve the update of the leading row and produce the sum of squares from which rotation coefficients are derived. The square root is taken outside this block. The determinant mode (a*d - b*c) serves the update of every remaining row. The configured mode is sticky. Compute operations carry only their operands, so one configure command covers a long run of operations of the same kind.

Operands are signed Q8.8 values. Results are full-precision signed products (Q16.16 scaled) widened by two guard bits, so no combination of inputs can overflow. The pipeline accepts one operation per clock and returns its result a fixed three cycles later.

Top module: `morph_dot_unit`

## Requirements
- R1: While reset is asserted and after it is released, `res_valid` is 0 and `res_data` is all zeros, and the active mode is the scalar product (code 0).
- R2: In scalar mode (code 0), lane 0 returns op0*op4. Operand i occupies `op_data[16*i+15:16*i]`. Lane l's result occupies `res_data[34*l+33:34*l]` as a signed 34-bit value.
- R3: In inner-product modes (code 1 = two terms, 2 = three terms, 3 = four terms), lane 0 returns the sum of op(i)*op(4+i) for i below the term count. Operands outside the active terms have no effect.
- R4: In determinant mode (code 4), lane 0 returns op0*op3 - op1*op2 and lane 1 returns op4*op7 - op5*op6. Both bits of `res_valid` are set.
- R5: An operation presented with `op_valid` in cycle t produces its result in cycle t+3. One operation is accepted every cycle, with no stall or bubble.
- R6: A strobe with a defined code (0 to 4) changes the mode from the next cycle onward. An operation accepted in the strobe cycle, and every operation already in flight, completes under the mode it was issued in.
- R7: A strobe carrying an undefined code (5, 6 or 7) leaves the active mode unchanged.
- R8: Results are exact for all operand values, including the most negative operand in every position. For example, a four-term product of -32768 with itself gives 2^32.
- R9: In non-determinant modes lane 1's valid bit is 0 and its data is zero. In a cycle with no result, both lanes read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_stb | input | 1 | Configure strobe |
| cfg_code | input | 3 | Mode code sampled with the strobe |
| op_valid | input | 1 | Operand bundle valid |
| op_data | input | 128 | Eight signed Q8.8 operands, operand i at bits 16i+15:16i |
| res_valid | output | 2 | Per-lane result valid (bit 1 only in determinant mode) |
| res_data | output | 68 | Two signed 34-bit lane results |

## Verification
The bench targets mode changes that arrive while older operations are still in the pipe, and a strobe that coincides with an operation. A design that applied the new mode too early would return results computed under the wrong shape for those operations. Stale values are placed in the unused operand slots of the two- and three-term modes, so a design that failed to zero the idle multipliers would return an inflated sum. Undefined codes are strobed between known operations to catch a design that decodes them into some mode. All-most-negative operands expose any result narrower than the full sum, which would wrap to a negative or zero value.

// File: rtl/mdu_pkg.sv
`timescale 1ns/1ps
package mdu_pkg;

   typedef enum logic [2:0] {
      MD_MUL  = 3'd0,
      MD_DOT2 = 3'd1,
      MD_DOT3 = 3'd2,
      MD_DOT4 = 3'd3,
      MD_DET  = 3'd4
   } mdu_mode_e;

   // A code is usable only if it names one of the five shapes
   function automatic logic code_known(input logic [2:0] code);
      return code <= 3'd4;
   endfunction

   // Number of multipliers carrying a live term in the inner-product shapes
   function automatic int active_terms(input mdu_mode_e m);
      case (m)
         MD_MUL:  return 1;
         MD_DOT2: return 2;
         MD_DOT3: return 3;
         default: return 4;
      endcase
   endfunction

endpackage

// File: rtl/mdu_steer.sv
`timescale 1ns/1ps
// Stage 1: route operands onto the multiplier inputs for the issued mode
module mdu_steer
   import mdu_pkg::*;
#(
   parameter int OP_W  = 16,
   parameter int N_MUL = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  mdu_mode_e                 in_mode,
   input  logic [2*N_MUL*OP_W-1:0]   in_ops,
   output logic                      s1_valid,
   output mdu_mode_e                 s1_mode,
   output logic [N_MUL*OP_W-1:0]     s1_x,
   output logic [N_MUL*OP_W-1:0]     s1_y,
   output logic [N_MUL-1:0]          s1_neg
);

   localparam int LANE_OPS = 4;

   logic [N_MUL*OP_W-1:0] nx, ny;
   logic [N_MUL-1:0]      nn;
   int                    terms;

   always_comb terms = active_terms(in_mode);

   for (genvar i = 0; i < N_MUL; i++) begin : g_route
      localparam int LN  = i / 2;
      localparam int JJ  = i % 2;
      localparam int DX  = LANE_OPS*LN + JJ;
      localparam int DY  = LANE_OPS*LN + LANE_OPS - 1 - JJ;
      localparam int VX  = i;
      localparam int VY  = N_MUL + i;
      always_comb begin
         if (in_mode == MD_DET) begin
            nx[i*OP_W +: OP_W] = in_ops[DX*OP_W +: OP_W];
            ny[i*OP_W +: OP_W] = in_ops[DY*OP_W +: OP_W];
            nn[i]              = (JJ == 1);
         end else if (i < terms) begin
            nx[i*OP_W +: OP_W] = in_ops[VX*OP_W +: OP_W];
            ny[i*OP_W +: OP_W] = in_ops[VY*OP_W +: OP_W];
            nn[i]              = 1'b0;
         end else begin
            nx[i*OP_W +: OP_W] = '0;
            ny[i*OP_W +: OP_W] = '0;
            nn[i]              = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_mode  <= MD_MUL;
         s1_x     <= '0;
         s1_y     <= '0;
         s1_neg   <= '0;
      end else begin
         s1_valid <= in_valid;
         s1_mode  <= in_mode;
         s1_x     <= in_valid ? nx : '0;
         s1_y     <= in_valid ? ny : '0;
         s1_neg   <= in_valid ? nn : '0;
      end
   end

   // R5
   steer_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid == ($past(in_valid) && $past(rst_n)));

   // R4
   steer_neg_only_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_neg != '0) |-> (s1_valid && s1_mode == MD_DET));

endmodule

// File: rtl/mdu_mult_bank.sv
`timescale 1ns/1ps
// Stage 2: signed multipliers with optional negation of the product
module mdu_mult_bank
   import mdu_pkg::*;
#(
   parameter int OP_W  = 16,
   parameter int N_MUL = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       s1_valid,
   input  mdu_mode_e                  s1_mode,
   input  logic [N_MUL*OP_W-1:0]      s1_x,
   input  logic [N_MUL*OP_W-1:0]      s1_y,
   input  logic [N_MUL-1:0]           s1_neg,
   output logic                       s2_valid,
   output mdu_mode_e                  s2_mode,
   output logic [N_MUL*2*OP_W-1:0]    s2_prod
);

   localparam int PROD_W = 2*OP_W;

   for (genvar i = 0; i < N_MUL; i++) begin : g_mul
      logic signed [PROD_W-1:0] raw;
      logic signed [PROD_W-1:0] adj;
      always_comb begin
         raw = $signed(s1_x[i*OP_W +: OP_W]) * $signed(s1_y[i*OP_W +: OP_W]);
         adj = s1_neg[i] ? -raw : raw;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) s2_prod[i*PROD_W +: PROD_W] <= '0;
         else        s2_prod[i*PROD_W +: PROD_W] <= adj;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_valid <= 1'b0;
         s2_mode  <= MD_MUL;
      end else begin
         s2_valid <= s1_valid;
         s2_mode  <= s1_mode;
      end
   end

   // R5
   mul_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s2_valid == ($past(s1_valid) && $past(rst_n)));

   // R6
   mul_mode_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(s1_valid) && $past(rst_n)) |-> (s2_mode == $past(s1_mode)));

endmodule

// File: rtl/mdu_adder_tree.sv
`timescale 1ns/1ps
// Stage 3: two-level adder tree, split into two lanes for determinants
module mdu_adder_tree
   import mdu_pkg::*;
#(
   parameter int OP_W  = 16,
   parameter int N_MUL = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          s2_valid,
   input  mdu_mode_e                     s2_mode,
   input  logic [N_MUL*2*OP_W-1:0]       s2_prod,
   output logic [1:0]                    res_valid,
   output logic [2*(2*OP_W+2)-1:0]       res_data
);

   localparam int PROD_W = 2*OP_W;
   localparam int RES_W  = PROD_W + 2;

   logic signed [RES_W-1:0] ext [N_MUL];
   logic signed [RES_W-1:0] lvl_lo, lvl_hi, total;

   for (genvar i = 0; i < N_MUL; i++) begin : g_ext
      assign ext[i] = RES_W'($signed(s2_prod[i*PROD_W +: PROD_W]));
   end

   always_comb begin
      lvl_lo = ext[0] + ext[1];
      lvl_hi = ext[2] + ext[3];
      total  = lvl_lo + lvl_hi;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 2'b00;
         res_data  <= '0;
      end else if (!s2_valid) begin
         res_valid <= 2'b00;
         res_data  <= '0;
      end else if (s2_mode == MD_DET) begin
         res_valid <= 2'b11;
         res_data  <= {lvl_hi, lvl_lo};
      end else begin
         res_valid <= 2'b01;
         res_data  <= {{RES_W{1'b0}}, total};
      end
   end

   // R9
   lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid[1] |-> res_valid[0]);

   // R9
   idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid[1] |-> (res_data[2*RES_W-1:RES_W] == '0));

endmodule

// File: rtl/morph_dot_unit.sv
`timescale 1ns/1ps
module morph_dot_unit
   import mdu_pkg::*;
#(
   parameter int OP_W   = 16,
   parameter int FRAC_W = 8,
   parameter int N_MUL  = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_stb,
   input  logic [2:0]                    cfg_code,
   input  logic                          op_valid,
   input  logic [2*N_MUL*OP_W-1:0]       op_data,
   output logic [1:0]                    res_valid,
   output logic [2*(2*OP_W+2)-1:0]       res_data
);

   localparam int PROD_W = 2*OP_W;

   // elaboration-time parameter checks
   if (N_MUL != 4) begin : g_bad_mul
      $error("morph_dot_unit: N_MUL must be 4 (two lanes of two multipliers)");
   end
   if (OP_W < 2) begin : g_bad_opw
      $error("morph_dot_unit: OP_W too small");
   end
   if (FRAC_W >= OP_W) begin : g_bad_frac
      $error("morph_dot_unit: FRAC_W must leave an integer part");
   end

   mdu_mode_e mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            mode_q <= MD_MUL;
      else if (cfg_stb && code_known(cfg_code)) mode_q <= mdu_mode_e'(cfg_code);
   end

   logic                   s1_valid, s2_valid;
   mdu_mode_e              s1_mode, s2_mode;
   logic [N_MUL*OP_W-1:0]  s1_x, s1_y;
   logic [N_MUL-1:0]       s1_neg;
   logic [N_MUL*PROD_W-1:0] s2_prod;

   mdu_steer #(.OP_W(OP_W), .N_MUL(N_MUL)) u_steer (
      .clk(clk), .rst_n(rst_n), .in_valid(op_valid), .in_mode(mode_q),
      .in_ops(op_data), .s1_valid(s1_valid), .s1_mode(s1_mode),
      .s1_x(s1_x), .s1_y(s1_y), .s1_neg(s1_neg));

   mdu_mult_bank #(.OP_W(OP_W), .N_MUL(N_MUL)) u_mul (
      .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_mode(s1_mode),
      .s1_x(s1_x), .s1_y(s1_y), .s1_neg(s1_neg),
      .s2_valid(s2_valid), .s2_mode(s2_mode), .s2_prod(s2_prod));

   mdu_adder_tree #(.OP_W(OP_W), .N_MUL(N_MUL)) u_tree (
      .clk(clk), .rst_n(rst_n), .s2_valid(s2_valid), .s2_mode(s2_mode),
      .s2_prod(s2_prod), .res_valid(res_valid), .res_data(res_data));

   // cycles since reset, saturating, so latency checks never look before reset
   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               since_rst <= 2'd0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   // R7
   bad_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_stb && !code_known(cfg_code)) |=> $stable(mode_q));

   // R6
   good_code_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_stb && code_known(cfg_code)) |=> (mode_q == $past(cfg_code)));

   // R5
   fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3) |-> (res_valid[0] == $past(op_valid, 3)));

   // R4
   dual_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3) |->
         (res_valid[1] == ($past(op_valid, 3) && $past(mode_q, 3) == MD_DET)));

endmodule

// File: tb/morph_dot_unit_test.sv
`timescale 1ns/1ps
module morph_dot_unit_test;

   localparam int OP_W  = 16;
   localparam int NOPS  = 8;
   localparam int RES_W = 2*OP_W + 2;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic                   rst_n    = 1'b0;
   logic                   cfg_stb  = 1'b0;
   logic [2:0]             cfg_code = 3'd0;
   logic                   op_valid = 1'b0;
   logic [NOPS*OP_W-1:0]   op_data  = '0;
   logic [1:0]             res_valid;
   logic [2*RES_W-1:0]     res_data;

   morph_dot_unit uut (
      .clk(clk), .rst_n(rst_n), .cfg_stb(cfg_stb), .cfg_code(cfg_code),
      .op_valid(op_valid), .op_data(op_data),
      .res_valid(res_valid), .res_data(res_data));

   int     checks = 0;
   int     errors = 0;
   int     mdl_mode = 0;
   bit     done = 1'b0;
   string  cur_tag = "R1";

   // expected-result pipe: index 2 is due now
   logic [1:0] ev [3];
   longint     e0 [3];
   longint     e1 [3];
   string      et [3];

   initial begin
      for (int k = 0; k < 3; k++) begin
         ev[k] = 2'b00; e0[k] = 0; e1[k] = 0; et[k] = "R1";
      end
   end

   function automatic longint opv(input int i);
      return longint'($signed(op_data[i*OP_W +: OP_W]));
   endfunction

   always @(negedge clk) begin
      longint     a0, a1, n0, n1;
      logic [1:0] nv;
      a0 = longint'($signed(res_data[RES_W-1:0]));
      a1 = longint'($signed(res_data[2*RES_W-1:RES_W]));
      checks++;
      if (res_valid !== ev[2] || a0 != e0[2] || a1 != e1[2]) begin
         errors++;
         $display("FAIL %s: valid=%b lane0=%0d lane1=%0d expected valid=%b lane0=%0d lane1=%0d",
                  et[2], res_valid, a0, a1, ev[2], e0[2], e1[2]);
      end
      for (int k = 2; k > 0; k--) begin
         ev[k] = ev[k-1]; e0[k] = e0[k-1]; e1[k] = e1[k-1]; et[k] = et[k-1];
      end
      nv = 2'b00; n0 = 0; n1 = 0;
      if (!rst_n) begin
         mdl_mode = 0;
      end else begin
         if (op_valid) begin
            if (mdl_mode == 4) begin
               nv = 2'b11;
               n0 = opv(0)*opv(3) - opv(1)*opv(2);
               n1 = opv(4)*opv(7) - opv(5)*opv(6);
            end else begin
               nv = 2'b01;
               for (int i = 0; i <= mdl_mode; i++) n0 += opv(i)*opv(4+i);
            end
         end
         if (cfg_stb && cfg_code <= 3'd4) mdl_mode = int'(cfg_code);
      end
      ev[0] = nv; e0[0] = n0; e1[0] = n1; et[0] = cur_tag;
   end

   task automatic cyc(input logic v, input logic [NOPS*OP_W-1:0] d,
                      input logic s, input logic [2:0] c, input string tag);
      @(posedge clk);
      #2;
      op_valid = v; op_data = d; cfg_stb = s; cfg_code = c; cur_tag = tag;
   endtask

   function automatic logic [NOPS*OP_W-1:0] pk(input int v0, v1, v2, v3, v4, v5, v6, v7);
      return {v7[15:0], v6[15:0], v5[15:0], v4[15:0],
              v3[15:0], v2[15:0], v1[15:0], v0[15:0]};
   endfunction

   function automatic logic [NOPS*OP_W-1:0] rnd();
      return {$urandom(), $urandom(), $urandom(), $urandom()};
   endfunction

   initial begin
      // R1: reset state
      repeat (3) cyc(1'b0, '0, 1'b0, 3'd0, "R1");
      @(posedge clk); #2; rst_n = 1'b1;
      repeat (3) cyc(1'b0, '0, 1'b0, 3'd0, "R1");

      // R2: scalar products
      cyc(1'b1, pk(3, 5, 7, 9, -4, 100, 100, 100), 1'b0, 3'd0, "R2");
      repeat (4) cyc(1'b1, rnd(), 1'b0, 3'd0, "R2");

      // R6: strobe and operation in the same cycle, old mode applies
      cyc(1'b1, pk(2, 3, 0, 0, 10, 20, 0, 0), 1'b1, 3'd1, "R6");
      // R3: two terms, stale values in unused slots ignored
      cyc(1'b1, pk(2, 3, 9, 9, 10, 20, 9, 9), 1'b0, 3'd0, "R3");
      cyc(1'b0, '0, 1'b1, 3'd2, "R3");
      repeat (5) cyc(1'b1, rnd(), 1'b0, 3'd0, "R3");
      cyc(1'b0, '0, 1'b1, 3'd3, "R3");

      // R5: back-to-back four-term products
      repeat (20) cyc(1'b1, rnd(), 1'b0, 3'd0, "R5");

      // R7: undefined codes leave the four-term mode in place
      cyc(1'b1, rnd(), 1'b1, 3'd6, "R7");
      cyc(1'b1, rnd(), 1'b1, 3'd5, "R7");
      cyc(1'b1, rnd(), 1'b1, 3'd7, "R7");
      repeat (3) cyc(1'b1, rnd(), 1'b0, 3'd0, "R7");

      // R4: dual determinants
      cyc(1'b0, '0, 1'b1, 3'd4, "R4");
      cyc(1'b1, pk(1, 2, 3, 4, 5, 6, 7, 8), 1'b0, 3'd0, "R4");
      repeat (10) cyc(1'b1, rnd(), 1'b0, 3'd0, "R4");
      // R6: switch while determinants are in flight
      cyc(1'b1, rnd(), 1'b1, 3'd1, "R6");
      cyc(1'b1, rnd(), 1'b0, 3'd0, "R6");
      cyc(1'b1, rnd(), 1'b1, 3'd4, "R6");
      cyc(1'b1, rnd(), 1'b0, 3'd0, "R6");

      // R8: extreme operands
      cyc(1'b0, '0, 1'b1, 3'd3, "R8");
      cyc(1'b1, pk(-32768, -32768, -32768, -32768, -32768, -32768, -32768, -32768), 1'b0, 3'd0, "R8");
      cyc(1'b1, pk(-32768, -32768, -32768, -32768, 32767, 32767, 32767, 32767), 1'b0, 3'd0, "R8");
      cyc(1'b0, '0, 1'b1, 3'd4, "R8");
      cyc(1'b1, pk(-32768, 32767, 32767, -32768, -32768, -32768, 32767, -32768), 1'b0, 3'd0, "R8");
      cyc(1'b1, pk(-32768, -32768, -32768, -32768, 32767, -32768, -32768, 32767), 1'b0, 3'd0, "R8");

      // R9: gaps in non-determinant mode
      cyc(1'b0, '0, 1'b1, 3'd1, "R9");
      for (int k = 0; k < 10; k++) cyc(k[0], rnd(), 1'b0, 3'd0, "R9");

      // R5 / R6: random traffic with random reconfiguration
      for (int k = 0; k < 300; k++) begin
         logic s;
         s = ($urandom() % 8) == 0;
         cyc(logic'($urandom() % 4 != 0), rnd(), s, 3'($urandom() % 8), "R5");
      end

      repeat (5) cyc(1'b0, '0, 1'b0, 3'd0, "R9");
      @(posedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #4000000;
      if (!done) begin
         errors++;
         $display("FAIL R5 watchdog: actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule